// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received Ethernet frames, presented as a byte stream with start, end and error markers, and stores them in buffers that software hands over through a ring of receive descriptors. Every descriptor slot holds a buffer address, a byte count and four flags: one says the slot is free for the hardware, one closes the ring, one marks the end of a frame and one marks a bad frame. The descriptors live in a small table inside the block. Software writes them through a slot write port and reads them back through a slot read port. Frame bytes go out through a plain memory write port, one byte per cycle.

Software fills the table with free slots, sets the ring-closing flag on the last slot only, and then issues a start pulse that names the first slot to use. Each frame goes into one slot. When the end marker arrives, the engine writes back the byte count, which includes the four trailing check bytes. It clears the free flag, sets the end-of-frame flag, sets the bad-frame flag when needed and moves to the next slot. If a frame begins while the current slot still belongs to software, the engine stops accepting frames. From then on it drops every frame whole and counts each drop. Only an explicit resume pulse from software lifts the stop.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset, `mem_we`, `frame_evt`, `stalled` and `drop_count` are 0 and no frame is accepted. A `start` pulse makes `cur_idx` equal to `start_idx` and arms the engine.
- R2: The engine accepts a frame when its first byte has `in_sof` = 1, the engine is not stalled and the current slot is free. Byte k of the frame (counting from 0) is written to address `ptr + k` of that slot. Writes come in order, one per byte, and each appears on `mem_we`/`mem_addr`/`mem_wdata` the cycle after the byte is presented.
- R3: When the byte with `in_eof` = 1 is taken, the slot is written back in the same cycle. Free becomes 0, end-of-frame becomes 1, the byte count becomes the number of bytes received (check bytes included), and the ring-closing flag keeps its value.
- R4: The bad-frame flag of the closed slot is 1 if `in_err` is 1 on the end byte, and 0 if the frame was good and fits.
- R5: Bytes beyond `MAX_LEN` are not written. The slot's byte count is `MAX_LEN` and its bad-frame flag is 1.
- R6: After closing a slot whose ring-closing flag is 1, `cur_idx` becomes 0. Otherwise it becomes the slot number plus one.
- R7: A frame that starts while the current slot is not free, or while `stalled` is 1, is dropped whole. It causes no memory write, `drop_count` goes up by exactly 1 and `stalled` becomes 1. Later frames are also dropped, even after software has freed the slot, until a resume pulse arrives.
- R8: A `kick` pulse clears `stalled`. The next frame then goes into the slot the engine stopped on.
- R9: `frame_evt` is a one-cycle pulse, raised once for each slot closed with the end-of-frame flag set.
- R10: A software slot write sets free, ring-closing and buffer address from `sw_empty`, `sw_wrap` and `sw_ptr`. It clears the byte count, end-of-frame and bad-frame. The slot read port shows the stored fields of `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms the engine and loads the first slot number |
| start_idx | input | IDX_W | First slot to use after start |
| kick | input | 1 | Software resume pulse, clears the stall |
| in_valid | input | 1 | A received byte is present |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Frame is bad, valid with in_eof |
| sw_we | input | 1 | Software slot write strobe |
| sw_idx | input | IDX_W | Slot being written by software |
| sw_empty | input | 1 | Free flag to store |
| sw_wrap | input | 1 | Ring-closing flag to store |
| sw_ptr | input | ADDR_W | Buffer address to store |
| rd_idx | input | IDX_W | Slot shown on the read port |
| rd_empty | output | 1 | Free flag of the read slot |
| rd_wrap | output | 1 | Ring-closing flag of the read slot |
| rd_last | output | 1 | End-of-frame flag of the read slot |
| rd_err | output | 1 | Bad-frame flag of the read slot |
| rd_len | output | LEN_W | Byte count of the read slot |
| rd_ptr | output | ADDR_W | Buffer address of the read slot |
| mem_we | output | 1 | Frame byte write strobe |
| mem_addr | output | ADDR_W | Frame byte address |
| mem_wdata | output | 8 | Frame byte |
| frame_evt | output | 1 | Slot closed pulse |
| stalled | output | 1 | Engine is stopped and drops frames |
| drop_count | output | DROP_W | Number of dropped frames |
| cur_idx | output | IDX_W | Slot the engine will use next |

## Verification
The bench builds the block with four slots and `MAX_LEN` = 20, with 16-bit addresses. With four slots, a run of a few frames goes all the way round the ring, from a start slot other than zero, through the ring-closing slot and back to slot 0. That run then catches up with a slot software has not returned, so it reaches the stall. With the small maximum, a 25-byte frame exercises the truncation path in a short run. Frames of one byte, with the start and end markers on the same byte, cover the shortest close.

// File: rtl/rx_desc_ring_pkg.sv
package rx_desc_ring_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HUNT = 2'd1,
    ST_RECV = 2'd2,
    ST_DROP = 2'd3
  } rx_state_e;

  // Slot that follows idx: the ring-closing flag or the end of the table sends it to 0
  function automatic int rxr_next_slot(input int idx, input logic wrap, input int count);
    if (wrap || (idx + 1 >= count)) return 0;
    return idx + 1;
  endfunction

  // Byte count after one more byte, held at the maximum
  function automatic int rxr_len_after(input int cnt, input int max_len);
    if (cnt >= max_len) return max_len;
    return cnt + 1;
  endfunction

endpackage

// File: rtl/rx_slot_table.sv
module rx_slot_table #(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3,
  parameter int LEN_W    = 11,
  parameter int ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_empty,
  input  logic              sw_wrap,
  input  logic [ADDR_W-1:0] sw_ptr,
  input  logic              close_stb,
  input  logic [IDX_W-1:0]  close_idx,
  input  logic [LEN_W-1:0]  close_len,
  input  logic              close_err,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              look_empty,
  output logic              look_wrap,
  output logic [ADDR_W-1:0] look_ptr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_empty,
  output logic              rd_wrap,
  output logic              rd_last,
  output logic              rd_err,
  output logic [LEN_W-1:0]  rd_len,
  output logic [ADDR_W-1:0] rd_ptr
);

  logic [NUM_DESC-1:0] empty_q, wrap_q, last_q, err_q;
  logic [LEN_W-1:0]    len_q [NUM_DESC];
  logic [ADDR_W-1:0]   ptr_q [NUM_DESC];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_slot
    logic hit_eng, hit_sw;
    assign hit_eng = close_stb && (close_idx == IDX_W'(g));
    assign hit_sw  = sw_we && (sw_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        empty_q[g] <= 1'b0;
        wrap_q[g]  <= 1'b0;
        last_q[g]  <= 1'b0;
        err_q[g]   <= 1'b0;
        len_q[g]   <= '0;
        ptr_q[g]   <= '0;
      end else if (hit_eng) begin
        // engine write-back wins over a software write to the same slot
        empty_q[g] <= 1'b0;
        last_q[g]  <= 1'b1;
        err_q[g]   <= close_err;
        len_q[g]   <= close_len;
      end else if (hit_sw) begin
        empty_q[g] <= sw_empty;
        wrap_q[g]  <= sw_wrap;
        last_q[g]  <= 1'b0;
        err_q[g]   <= 1'b0;
        len_q[g]   <= '0;
        ptr_q[g]   <= sw_ptr;
      end
    end
  end

  assign look_empty = empty_q[look_idx];
  assign look_wrap  = wrap_q[look_idx];
  assign look_ptr   = ptr_q[look_idx];

  assign rd_empty = empty_q[rd_idx];
  assign rd_wrap  = wrap_q[rd_idx];
  assign rd_last  = last_q[rd_idx];
  assign rd_err   = err_q[rd_idx];
  assign rd_len   = len_q[rd_idx];
  assign rd_ptr   = ptr_q[rd_idx];

endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
  import rx_desc_ring_pkg::*;
#(
  parameter int NUM_DESC = 8,
  parameter int IDX_W    = 3,
  parameter int LEN_W    = 11,
  parameter int ADDR_W   = 16,
  parameter int MAX_LEN  = 1518,
  parameter int DROP_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              kick,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  output logic [IDX_W-1:0]  look_idx,
  input  logic              look_empty,
  input  logic              look_wrap,
  input  logic [ADDR_W-1:0] look_ptr,
  output logic              close_stb,
  output logic [IDX_W-1:0]  close_idx,
  output logic [LEN_W-1:0]  close_len,
  output logic              close_err,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              frame_evt,
  output logic              stalled,
  output logic [DROP_W-1:0] drop_count
);

  rx_state_e         st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              trunc_q, stall_q;

  logic take_new, refuse, in_body, room, byte_wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [IDX_W-1:0]  idx_after;

  always_comb begin
    take_new  = in_valid && in_sof && (st_q == ST_HUNT) && !stall_q && look_empty;
    refuse    = in_valid && in_sof && (st_q == ST_HUNT) && (stall_q || !look_empty);
    in_body   = in_valid && (st_q == ST_RECV);
    room      = cnt_q < LEN_W'(MAX_LEN);
    byte_wr   = take_new || (in_body && room);
    wr_addr   = take_new ? look_ptr : ptr_q + ADDR_W'(cnt_q);
    close_stb = (take_new || in_body) && in_eof;
    close_idx = idx_q;
    close_len = take_new ? LEN_W'(1) : LEN_W'(rxr_len_after(32'(cnt_q), MAX_LEN));
    close_err = in_err || (in_body && !room) || (!take_new && trunc_q);
    idx_after = IDX_W'(rxr_next_slot(32'(idx_q), look_wrap, NUM_DESC));
  end

  assign look_idx = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_OFF;
      idx_q      <= '0;
      cnt_q      <= '0;
      ptr_q      <= '0;
      trunc_q    <= 1'b0;
      stall_q    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      frame_evt  <= 1'b0;
      drop_count <= '0;
    end else begin
      mem_we    <= byte_wr;
      frame_evt <= close_stb;
      if (byte_wr) begin
        mem_addr  <= wr_addr;
        mem_wdata <= in_data;
      end
      if (kick) stall_q <= 1'b0;
      if (start) begin
        idx_q   <= start_idx;
        st_q    <= ST_HUNT;
        stall_q <= 1'b0;
      end else begin
        unique case (st_q)
          ST_HUNT: begin
            if (take_new) begin
              ptr_q   <= look_ptr;
              cnt_q   <= LEN_W'(1);
              trunc_q <= 1'b0;
              if (in_eof) idx_q <= idx_after;
              else        st_q  <= ST_RECV;
            end else if (refuse) begin
              drop_count <= drop_count + 1'b1;
              stall_q    <= 1'b1;
              if (!in_eof) st_q <= ST_DROP;
            end
          end
          ST_RECV: begin
            if (in_valid) begin
              if (room) cnt_q   <= cnt_q + 1'b1;
              else      trunc_q <= 1'b1;
              if (in_eof) begin
                idx_q <= idx_after;
                st_q  <= ST_HUNT;
              end
            end
          end
          ST_DROP: begin
            if (in_valid && in_eof) st_q <= ST_HUNT;
          end
          default: ;
        endcase
      end
    end
  end

  assign stalled = stall_q;

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int NUM_DESC = 8,
  parameter int ADDR_W   = 16,
  parameter int MAX_LEN  = 1518,
  parameter int DROP_W   = 16,
  localparam int IDX_W   = $clog2(NUM_DESC),
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              kick,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic              sw_empty,
  input  logic              sw_wrap,
  input  logic [ADDR_W-1:0] sw_ptr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_empty,
  output logic              rd_wrap,
  output logic              rd_last,
  output logic              rd_err,
  output logic [LEN_W-1:0]  rd_len,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              frame_evt,
  output logic              stalled,
  output logic [DROP_W-1:0] drop_count,
  output logic [IDX_W-1:0]  cur_idx
);

  // internal events exposed as named wires for the checker
  logic              eng_close_stb;
  logic [IDX_W-1:0]  eng_close_idx;
  logic [LEN_W-1:0]  eng_close_len;
  logic              eng_close_err;
  logic [IDX_W-1:0]  slot_idx;
  logic              slot_empty;
  logic              slot_wrap;
  logic [ADDR_W-1:0] slot_ptr;

  rx_slot_table #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_empty(sw_empty), .sw_wrap(sw_wrap), .sw_ptr(sw_ptr),
    .close_stb(eng_close_stb), .close_idx(eng_close_idx),
    .close_len(eng_close_len), .close_err(eng_close_err),
    .look_idx(slot_idx), .look_empty(slot_empty), .look_wrap(slot_wrap), .look_ptr(slot_ptr),
    .rd_idx(rd_idx), .rd_empty(rd_empty), .rd_wrap(rd_wrap), .rd_last(rd_last),
    .rd_err(rd_err), .rd_len(rd_len), .rd_ptr(rd_ptr)
  );

  rx_frame_writer #(
    .NUM_DESC(NUM_DESC), .IDX_W(IDX_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
    .MAX_LEN(MAX_LEN), .DROP_W(DROP_W)
  ) u_writer (
    .clk(clk), .rst_n(rst_n),
    .start(start), .start_idx(start_idx), .kick(kick),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .look_idx(slot_idx), .look_empty(slot_empty), .look_wrap(slot_wrap), .look_ptr(slot_ptr),
    .close_stb(eng_close_stb), .close_idx(eng_close_idx),
    .close_len(eng_close_len), .close_err(eng_close_err),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .frame_evt(frame_evt), .stalled(stalled), .drop_count(drop_count)
  );

  assign cur_idx = slot_idx;

endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk #(
  parameter int IDX_W   = 3,
  parameter int LEN_W   = 11,
  parameter int MAX_LEN = 1518,
  parameter int DROP_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_we,
  input logic              stalled,
  input logic [DROP_W-1:0] drop_count,
  input logic [IDX_W-1:0]  cur_idx,
  input logic              close_stb,
  input logic              close_wrap,
  input logic [LEN_W-1:0]  close_len
);

  // R6: closing the ring-closing slot returns the engine to slot 0
  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    close_stb && close_wrap && !start |=> cur_idx == '0);

  // R5: a written-back byte count is never zero and never above the maximum
  a_r5_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
    close_stb |-> (close_len != '0) && (close_len <= LEN_W'(MAX_LEN)));

  // R7: the drop counter moves by exactly one at a time
  a_r7_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count != $past(drop_count) |-> drop_count == $past(drop_count) + 1'b1);

  // R7: while stalled, no frame byte reaches memory
  a_r7_no_write_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stalled) |-> !mem_we);

endmodule

bind rx_desc_ring rx_desc_ring_chk #(
  .IDX_W(IDX_W), .LEN_W(LEN_W), .MAX_LEN(MAX_LEN), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_we(mem_we), .stalled(stalled),
  .drop_count(drop_count), .cur_idx(cur_idx), .close_stb(eng_close_stb),
  .close_wrap(slot_wrap), .close_len(eng_close_len)
);

// File: tb/tb_rx_desc_ring.sv
module tb_rx_desc_ring;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 4;
  localparam int AW    = 16;
  localparam int MAXL  = 20;
  localparam int DW    = 16;
  localparam int IW    = $clog2(NDESC);
  localparam int LW    = $clog2(MAXL + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, kick = 0, in_valid = 0, in_sof = 0, in_eof = 0, in_err = 0;
  logic [IW-1:0] start_idx = '0, sw_idx = '0, rd_idx = '0;
  logic [7:0] in_data = '0;
  logic sw_we = 0, sw_empty = 0, sw_wrap = 0;
  logic [AW-1:0] sw_ptr = '0;
  logic rd_empty, rd_wrap, rd_last, rd_err;
  logic [LW-1:0] rd_len;
  logic [AW-1:0] rd_ptr, mem_addr;
  logic mem_we, frame_evt, stalled;
  logic [7:0] mem_wdata;
  logic [DW-1:0] drop_count;
  logic [IW-1:0] cur_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_ring #(.NUM_DESC(NDESC), .ADDR_W(AW), .MAX_LEN(MAXL), .DROP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx), .kick(kick),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_empty(sw_empty), .sw_wrap(sw_wrap), .sw_ptr(sw_ptr),
    .rd_idx(rd_idx), .rd_empty(rd_empty), .rd_wrap(rd_wrap), .rd_last(rd_last),
    .rd_err(rd_err), .rd_len(rd_len), .rd_ptr(rd_ptr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .frame_evt(frame_evt), .stalled(stalled), .drop_count(drop_count), .cur_idx(cur_idx)
  );

  int total = 0, bad = 0, evt_seen = 0;
  bit done = 0, prev_evt = 0;
  logic [AW+7:0] expq[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        if (expq.size() == 0) chk(0, "R7 unexpected write", {mem_addr, mem_wdata}, 0);
        else begin
          logic [AW+7:0] e;
          e = expq.pop_front();
          chk({mem_addr, mem_wdata} == e, "R2 write", {mem_addr, mem_wdata}, e);
        end
      end
      if (frame_evt) evt_seen++;
      if (frame_evt && prev_evt) chk(0, "R9 pulse width", 2, 1);
      prev_evt = frame_evt;
    end
  end

  task automatic sw_slot(input int i, input bit emp, input bit wr, input logic [AW-1:0] p);
    @(negedge clk);
    sw_we = 1; sw_idx = IW'(i); sw_empty = emp; sw_wrap = wr; sw_ptr = p;
    @(negedge clk);
    sw_we = 0;
  endtask

  // driver: pushes the expected writes, then drives the bytes
  task automatic send(input int n, input logic [AW-1:0] base, input bit err,
                      input bit accept, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      if (accept && i < MAXL) expq.push_back({base + AW'(i), seed + 8'(i)});
    end
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = seed + 8'(i);
      in_sof = (i == 0); in_eof = (i == n - 1); in_err = err && (i == n - 1);
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_slot(input int i, input bit emp, input bit last, input bit err,
                          input bit wr, input int len, input string req);
    rd_idx = IW'(i); #1;
    chk(rd_empty == emp, req, rd_empty, emp);
    chk(rd_last == last, req, rd_last, last);
    chk(rd_err == err, req, rd_err, err);
    chk(rd_wrap == wr, req, rd_wrap, wr);
    chk(rd_len == LW'(len), req, rd_len, len);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk(mem_we == 0, "R1 mem_we", mem_we, 0);
    chk(frame_evt == 0, "R1 frame_evt", frame_evt, 0);
    chk(stalled == 0, "R1 stalled", stalled, 0);
    chk(drop_count == 0, "R1 drop_count", drop_count, 0);
    // R1: not armed, frame ignored
    send(3, 16'h0, 0, 0, 8'h10);
    chk(evt_seen == 0, "R1 no close before start", evt_seen, 0);

    for (int i = 0; i < NDESC; i++) sw_slot(i, 1, i == NDESC - 1, AW'((i + 1) * 16'h100));
    // R10: software write visible on read port
    rd_idx = IW'(NDESC - 1); #1;
    chk(rd_ptr == 16'h400, "R10 ptr", rd_ptr, 16'h400);
    chk_slot(NDESC - 1, 1, 0, 0, 1, 0, "R10 slot fields");

    @(negedge clk); start = 1; start_idx = IW'(1);
    @(negedge clk); start = 0;
    chk(cur_idx == 1, "R1 start slot", cur_idx, 1);

    // R2 R3: good 6-byte frame into slot 1
    send(6, 16'h200, 0, 1, 8'h40);
    chk_slot(1, 0, 1, 0, 0, 6, "R3 close slot1");
    chk(cur_idx == 2, "R6 advance", cur_idx, 2);
    chk(evt_seen == 1, "R9 one event", evt_seen, 1);

    // R5: 25-byte frame truncated to 20
    send(25, 16'h300, 0, 1, 8'h80);
    chk_slot(2, 0, 1, 1, 0, MAXL, "R5 truncated");

    // R4 R6: bad frame into ring-closing slot
    send(3, 16'h400, 1, 1, 8'hc0);
    chk_slot(3, 0, 1, 1, 1, 3, "R4 err flag");
    chk(cur_idx == 0, "R6 wrap to zero", cur_idx, 0);

    // R3: single byte frame
    send(1, 16'h100, 0, 1, 8'h55);
    chk_slot(0, 0, 1, 0, 0, 1, "R3 one byte");
    chk(cur_idx == 1, "R6 after slot0", cur_idx, 1);

    // R7: slot 1 not free -> drop and stall
    send(5, 16'h200, 0, 0, 8'h20);
    chk(stalled == 1, "R7 stalled", stalled, 1);
    chk(drop_count == 1, "R7 drop count", drop_count, 1);
    chk_slot(1, 0, 1, 0, 0, 6, "R7 slot untouched");

    // R7: freed slot without kick still drops
    sw_slot(1, 1, 0, 16'h500);
    send(4, 16'h500, 0, 0, 8'h30);
    chk(drop_count == 2, "R7 drop w/o kick", drop_count, 2);
    chk_slot(1, 1, 0, 0, 0, 0, "R7 freed slot unused");

    // R8: kick resumes into slot 1
    @(negedge clk); kick = 1;
    @(negedge clk); kick = 0;
    chk(stalled == 0, "R8 stall cleared", stalled, 0);
    send(4, 16'h500, 0, 1, 8'h90);
    chk_slot(1, 0, 1, 0, 0, 4, "R8 resumed slot1");
    chk(cur_idx == 2, "R8 advance", cur_idx, 2);

    chk(evt_seen == 5, "R9 event total", evt_seen, 5);
    chk(expq.size() == 0, "R2 all writes seen", expq.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule